// File: doc/BRIEF.md
# Filtered Pin-Change Wake Monitor

This block decides when a system in deep sleep should be woken by activity on its pins. On a sleep-entry strobe it takes a snapshot of the synchronized level of every monitored input and uses it as the reference. While asleep, it watches each pin whose wake-enable bit is set, and a set of auxiliary wake sources such as serial-port activity lines and an interrupt line. It emits a single wake pulse as soon as any watched input no longer matches its snapshot. Rising edges, falling edges and levels are all treated alike.

Glitch suppression is chosen per source group. All pins share one filter select, and each auxiliary source has its own. A filtered input counts as changed only after a run of consecutive samples agree with one another and differ from the snapshot. The samples are taken on a slow tick supplied from outside. Pin-based wake is gated by a global select. A sticky status bit records that pin activity caused the wake, but not which pin did. A pin whose digital input is held at constant 1, as an analog-mode pin is, can therefore never wake the system.

Top module: `wake_monitor`

## Requirements
- R1: On the clock edge that samples `sleep_enter` high, the block captures the synchronized level of every pin and auxiliary input as its reference, arms itself, and clears `gpio_woke`. An input that stays equal to its reference never produces a wake.
- R2: With filtering off, an enabled pin that differs from its reference in either direction raises `wake_req` on the third rising clock edge after the change reaches the pin input. That delay is two synchronizer stages plus one output register.
- R3: A pin whose bit in `pin_wake_en` is 0 never causes a wake.
- R4: While `gpio_sel` is 0, no pin can cause a wake and `gpio_woke` is never set.
- R5: With filtering on, a source is treated as changed only once `FILT_LEN` (default 3) consecutive `tick` samples differ from its reference. `wake_req` rises one clock after the edge that takes the last of those samples.
- R6: A filtered sample equal to the reference, or unequal to the previous sample, restarts the consecutive count from zero or one.
- R7: Filter select bit 0 of `filt_en` applies to all pins, and bit k+1 applies to auxiliary source k.
- R8: A change on auxiliary source k wakes the system regardless of `gpio_sel`, and it does not set `gpio_woke`.
- R9: `wake_req` is a one-cycle pulse and is produced at most once per sleep. Further changes are ignored until the next `sleep_enter`.
- R10: `gpio_woke` is set by a wake that has a pin among its causes. It then stays set until `gpio_woke_clr` or `sleep_enter`.
- R11: After reset the block is not armed: `wake_req` and `gpio_woke` are 0, and input changes cause no wake before the first `sleep_enter`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Pin levels (asynchronous) |
| aux_in | input | NUM_AUX | Auxiliary wake source levels (asynchronous) |
| pin_wake_en | input | NUM_PINS | Per-pin wake enable |
| filt_en | input | NUM_AUX+1 | Filter select: bit 0 pins, bit k+1 auxiliary source k |
| gpio_sel | input | 1 | Global enable for pin-based wake |
| sleep_enter | input | 1 | One-cycle strobe: capture references and arm |
| tick | input | 1 | One-cycle slow sampling strobe for the filters |
| gpio_woke_clr | input | 1 | One-cycle strobe clearing `gpio_woke` |
| wake_req | output | 1 | One-cycle wake pulse |
| gpio_woke | output | 1 | Sticky: last wake had a pin among its causes |

## Verification
The hardest situation to reach is a filtered run that is broken part way through. A pin has to go off its reference for one tick, come back for the next, and then stay off. Only then does a wake that comes too early expose a counter that failed to restart. The bench holds the pin level steady across each `tick` pulse it drives by hand, and moves the pin only between pulses. This fixes exactly which value each sample sees, so the bench can predict the tick on which the wake must appear.

// File: rtl/wm_pkg.sv
package wm_pkg;
   // Next value of a consecutive-sample counter that saturates at lim.
   function automatic int unsigned wm_next_cnt(input logic sample,
                                               input logic prev,
                                               input logic refv,
                                               input int unsigned cnt,
                                               input int unsigned lim);
      if (sample == refv)        return 0;
      else if (sample != prev)   return 1;
      else if (cnt >= lim)       return lim;
      else                       return cnt + 1;
   endfunction
endpackage

// File: rtl/wm_sync.sv
module wm_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (WIDTH < 1)  $error("wm_sync: WIDTH must be at least 1");
   if (STAGES < 2) $error("wm_sync: STAGES must be at least 2");

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= din;
         else             stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wm_chan.sv
module wm_chan #(
   parameter int FILT_LEN     = 3,
   parameter bit FILT_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_enter,
   input  logic tick,
   input  logic filt_on,
   input  logic din,
   output logic evt
);
   import wm_pkg::*;

   localparam int CW = $clog2(FILT_LEN + 1);

   if (FILT_LEN < 2) $error("wm_chan: FILT_LEN must be at least 2");

   logic ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ref_q <= 1'b0;
      else if (sleep_enter) ref_q <= din;
   end

   if (FILT_SUPPORT) begin : g_filt
      logic          prev_q;
      logic [CW-1:0] cnt_q;
      logic          raw_diff;

      assign raw_diff = (din != ref_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
         end else if (sleep_enter) begin
            prev_q <= din;
            cnt_q  <= '0;
         end else if (tick) begin
            prev_q <= din;
            cnt_q  <= CW'(wm_next_cnt(din, prev_q, ref_q, int'(cnt_q), FILT_LEN));
         end
      end

      assign evt = filt_on ? (cnt_q == CW'(FILT_LEN)) : raw_diff;

      // R5: a filtered event can only appear right after a sampling tick
      assert_filt_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (filt_on && $stable(filt_on) && $rose(evt)) |-> $past(tick));

      // R6: a tick that samples the reference value leaves the count empty
      assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && !sleep_enter && din == ref_q) |=> (cnt_q == '0));
   end else begin : g_nofilt
      assign evt = (din != ref_q);
   end

   // R1: the reference only moves on a sleep-entry strobe
   assert_ref_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_enter |=> $stable(ref_q));
endmodule

// File: rtl/wake_monitor.sv
module wake_monitor #(
   parameter int NUM_PINS     = 8,
   parameter int NUM_AUX      = 3,
   parameter int FILT_LEN     = 3,
   parameter int SYNC_STAGES  = 2,
   parameter bit FILT_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_AUX-1:0]  aux_in,
   input  logic [NUM_PINS-1:0] pin_wake_en,
   input  logic [NUM_AUX:0]    filt_en,
   input  logic                gpio_sel,
   input  logic                sleep_enter,
   input  logic                tick,
   input  logic                gpio_woke_clr,
   output logic                wake_req,
   output logic                gpio_woke
);
   localparam int NSRC = NUM_PINS + NUM_AUX;

   if (NUM_PINS < 1) $error("wake_monitor: NUM_PINS must be at least 1");
   if (NUM_AUX < 1)  $error("wake_monitor: NUM_AUX must be at least 1");

   logic [NSRC-1:0]     src_sync;
   logic [NSRC-1:0]     src_evt;
   logic [NUM_PINS-1:0] pin_evt;
   logic [NUM_AUX-1:0]  aux_evt;
   logic                pin_hit, aux_hit, hit;
   logic                armed_q;

   wm_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({aux_in, pin_in}),
      .dout (src_sync)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic fsel;
      if (i < NUM_PINS) begin : g_pin
         assign fsel = filt_en[0];
      end else begin : g_aux
         assign fsel = filt_en[i - NUM_PINS + 1];
      end
      wm_chan #(.FILT_LEN(FILT_LEN), .FILT_SUPPORT(FILT_SUPPORT)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .sleep_enter(sleep_enter),
         .tick       (tick),
         .filt_on    (fsel),
         .din        (src_sync[i]),
         .evt        (src_evt[i])
      );
   end

   assign pin_evt = src_evt[NUM_PINS-1:0];
   assign aux_evt = src_evt[NSRC-1:NUM_PINS];
   assign pin_hit = gpio_sel && |(pin_evt & pin_wake_en);
   assign aux_hit = |aux_evt;
   assign hit     = armed_q && (pin_hit || aux_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         wake_req  <= 1'b0;
         gpio_woke <= 1'b0;
      end else begin
         wake_req <= hit;
         if (sleep_enter) armed_q <= 1'b1;
         else if (hit)    armed_q <= 1'b0;
         if (sleep_enter)        gpio_woke <= 1'b0;
         else if (hit && pin_hit) gpio_woke <= 1'b1;
         else if (gpio_woke_clr) gpio_woke <= 1'b0;
      end
   end

   // R9: wake is a single-cycle pulse
   assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   // R10: status only rises together with a wake pulse
   assert_status_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gpio_woke) |-> wake_req);

   // R10: status holds without a clear or a new sleep
   assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (gpio_woke && !gpio_woke_clr && !sleep_enter) |=> gpio_woke);

   // R1: sleep entry leaves the status clear
   assert_status_sleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_enter |=> !gpio_woke);

   // R4: with pin wake disabled, status never rises
   assert_sel_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !gpio_sel |=> !$rose(gpio_woke));
endmodule

// File: tb/sim_wake_monitor.sv
module sim_wake_monitor;
   localparam int NP = 8;
   localparam int NA = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic [NA-1:0] aux_in = '0;
   logic [NP-1:0] pin_wake_en = '0;
   logic [NA:0]   filt_en = '0;
   logic          gpio_sel = 1'b0;
   logic          sleep_enter = 1'b0;
   logic          tick = 1'b0;
   logic          gpio_woke_clr = 1'b0;
   logic          wake_req, gpio_woke;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wake_monitor #(.NUM_PINS(NP), .NUM_AUX(NA), .FILT_LEN(3)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .aux_in(aux_in),
      .pin_wake_en(pin_wake_en), .filt_en(filt_en), .gpio_sel(gpio_sel),
      .sleep_enter(sleep_enter), .tick(tick), .gpio_woke_clr(gpio_woke_clr),
      .wake_req(wake_req), .gpio_woke(gpio_woke)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // counts wake pulses over n cycles
   task automatic quiet(input string req, input int n);
      int seen = 0;
      for (int k = 0; k < n; k++) begin
         step(1);
         if (wake_req) seen++;
      end
      n_run++;
      if (seen != 0) begin
         n_fail++;
         $display("FAIL %s quiet window: actual %0d pulses expected 0", req, seen);
      end
   endtask

   task automatic do_sleep();
      step(4);
      sleep_enter = 1'b1;
      step(1);
      sleep_enter = 1'b0;
   endtask

   task automatic do_tick();
      tick = 1'b1;
      step(1);
      tick = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11", "wake_req after reset", wake_req, 1'b0);
      chk("R11", "gpio_woke after reset", gpio_woke, 1'b0);
      pin_wake_en = '1; gpio_sel = 1'b1;
      pin_in = 8'hA5; aux_in = 3'b101;
      quiet("R11", 10);
   endtask

   task automatic t_unfilt_rise();
      pin_in = 8'h00; aux_in = '0; filt_en = '0;
      do_sleep();
      quiet("R1", 8);
      chk("R1", "status after sleep", gpio_woke, 1'b0);
      pin_in[3] = 1'b1;
      step(2);
      chk("R2", "no wake before third edge", wake_req, 1'b0);
      step(1);
      chk("R2", "wake on third edge (rise)", wake_req, 1'b1);
      chk("R10", "status set by pin wake", gpio_woke, 1'b1);
      step(1);
      chk("R9", "pulse is one cycle", wake_req, 1'b0);
      pin_in[5] = 1'b1;
      quiet("R9", 8);
   endtask

   task automatic t_unfilt_fall();
      pin_in = 8'hFF;
      do_sleep();
      quiet("R1", 6);
      pin_in[0] = 1'b0;
      step(3);
      chk("R2", "wake on third edge (fall)", wake_req, 1'b1);
   endtask

   task automatic t_mask();
      pin_in = 8'h00; pin_wake_en = 8'h0F;
      do_sleep();
      pin_in[6] = 1'b1;
      quiet("R3", 10);
      chk("R3", "status after masked change", gpio_woke, 1'b0);
      pin_in[1] = 1'b1;
      step(3);
      chk("R3", "enabled pin still wakes", wake_req, 1'b1);
      pin_wake_en = '1;
   endtask

   task automatic t_sel();
      pin_in = 8'h00; gpio_sel = 1'b0;
      do_sleep();
      pin_in = 8'hFF;
      quiet("R4", 10);
      chk("R4", "status with select clear", gpio_woke, 1'b0);
      aux_in[2] = 1'b1;
      step(3);
      chk("R8", "aux wakes with select clear", wake_req, 1'b1);
      chk("R8", "aux does not set status", gpio_woke, 1'b0);
      gpio_sel = 1'b1; aux_in = '0;
   endtask

   task automatic t_filtered();
      pin_in = 8'h00; filt_en = 4'b0001;
      do_sleep();
      pin_in[2] = 1'b1;
      quiet("R5", 6);
      do_tick();
      step(3);
      do_tick();
      quiet("R5", 5);
      do_tick();
      chk("R5", "no wake at third sampling edge", wake_req, 1'b0);
      step(1);
      chk("R5", "wake one clock after third sample", wake_req, 1'b1);
      chk("R10", "status set by filtered pin", gpio_woke, 1'b1);
   endtask

   task automatic t_glitch();
      pin_in = 8'h00; filt_en = 4'b0001;
      do_sleep();
      pin_in[4] = 1'b1; step(3); do_tick();
      pin_in[4] = 1'b0; step(3); do_tick();
      pin_in[4] = 1'b1; step(3); do_tick();
      do_tick();
      quiet("R6", 6);
      do_tick();
      step(1);
      chk("R6", "wake after unbroken run of three", wake_req, 1'b1);
   endtask

   task automatic t_groups();
      pin_in = 8'h00; aux_in = '0; filt_en = 4'b0001;
      do_sleep();
      pin_in[7] = 1'b1;
      quiet("R7", 8);
      aux_in[0] = 1'b1;
      step(3);
      chk("R7", "unfiltered aux0 wakes while pins filtered", wake_req, 1'b1);
      pin_in = 8'h00; aux_in = '0; filt_en = 4'b0100;
      do_sleep();
      aux_in[1] = 1'b1;
      quiet("R7", 8);
      do_tick(); do_tick(); do_tick();
      step(1);
      chk("R7", "filtered aux1 wakes after three ticks", wake_req, 1'b1);
      aux_in = '0; filt_en = '0;
   endtask

   task automatic t_clear();
      pin_in = 8'h00;
      do_sleep();
      pin_in[0] = 1'b1;
      step(4);
      chk("R10", "status set", gpio_woke, 1'b1);
      step(5);
      chk("R10", "status holds", gpio_woke, 1'b1);
      gpio_woke_clr = 1'b1; step(1); gpio_woke_clr = 1'b0;
      chk("R10", "status cleared by strobe", gpio_woke, 1'b0);
      pin_in[0] = 1'b0; step(4);
      pin_in[0] = 1'b1; step(4);
      chk("R10", "set again then sleep entry", gpio_woke, 1'b0);
      do_sleep();
      pin_in[0] = 1'b0;
      step(3);
      chk("R10", "status set again", gpio_woke, 1'b1);
      pin_in = '1;
      do_sleep();
      chk("R1", "status cleared by sleep entry", gpio_woke, 1'b0);
      quiet("R1", 6);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_unfilt_rise();
      t_unfilt_fall();
      t_mask();
      t_sel();
      t_filtered();
      t_glitch();
      t_groups();
      t_clear();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule